// File: doc/BRIEF.md
# Sector Transfer Address Checker and Sequencer

This block checks the addressing of each sector in a multi-sector disk read or write, one sector at a time. On a one-cycle request it looks at the drive's current cylinder, head and sector register, the transfer's first-sector flag, and the drive's attach and write-protect state. It then either accepts the sector or names the single most important fault. An accepted sector produces its linear block address, plus the sector and head values for the next sector. A track is 64 sectors and a sector is 256 bytes.

A rejected sector leaves the counters where they were and returns an error code. Two side-effect strobes come with the error: seek-incomplete for a bad cylinder, and drive-unsafe for a bad head on the first sector. The same head fault is reported in two different ways. On the first sector of a transfer it is an address compare failure. On a later sector it means the sequence ran off the last surface, which is a cylinder overflow.

A separate combinational byte path fills out a short sector. Each byte position past the supplied count takes the last supplied byte on a write and zero on a read.

Top module: `sxa_seq`

## Requirements
- R1: A request (`req_i` high for one cycle) is answered by `done_o` high for exactly one cycle on the following clock; without a request `done_o` stays low.
- R2: On acceptance `lba_o` equals ((cylinder × surfaces) + head) × 64 + sector, where sector is `sec_i[5:0]`.
- R3: With `attached_i` low, a known function reports error code 1 (transfer) before every other check, and neither side-effect strobe is raised.
- R4: Function 0x02 (write) on a write-protected drive reports code 2 (write protect) ahead of the cylinder and head checks; reads (0x01) and read-check (0x03) ignore write protect.
- R5: A cylinder at or above `cylinders_i` reports code 1 and raises `seek_inc_o`; it takes priority over a bad head.
- R6: A head at or above `surfaces_i` with `first_i` high reports code 3 (address compare fail) and raises `unsafe_o`.
- R7: The same head fault with `first_i` low reports code 4 (cylinder overflow) without `unsafe_o`.
- R8: On acceptance (code 0) `sec_o` is `sec_i[5:0]`+1 modulo 64, and `head_o` is `head_i`+1 exactly when the sector wraps from 63 to 0, otherwise `head_i`; bits 7:6 of `sec_i` have no effect.
- R9: With any nonzero code, `sec_o` equals `sec_i[5:0]` and `head_o` equals `head_i`.
- R10: Functions 0x04 to 0x07 run all address checks; if they all pass the result is code 2, otherwise the failing check's code and strobes.
- R11: Any function outside 0x01 to 0x07 reports code 1 with no address checks and no strobes.
- R12: `pad_byte_o` is `pad_data_i` when `pad_idx_i` < `pad_cnt_i`; otherwise it is `pad_last_i` if `pad_write_i` is high and 0 if it is low.
- R13: All registered outputs hold their values in cycles without a request; after reset they are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Check-this-sector request |
| func_i | input | 6 | Function code |
| attached_i | input | 1 | Drive has media attached |
| wprot_i | input | 1 | Drive is write protected |
| first_i | input | 1 | First sector of the transfer |
| cyl_i | input | 12 | Current cylinder |
| head_i | input | 5 | Current head |
| sec_i | input | 8 | Sector register (low 6 bits used) |
| surfaces_i | input | 5 | Surface count of the drive |
| cylinders_i | input | 12 | Cylinder count of the drive |
| done_o | output | 1 | Result strobe |
| err_o | output | 3 | 0 ok, 1 transfer, 2 write protect, 3 address compare, 4 cylinder overflow |
| lba_o | output | 23 | Linear block address |
| sec_o | output | 6 | Sector for the next transfer |
| head_o | output | 5 | Head for the next transfer |
| seek_inc_o | output | 1 | Set drive seek-incomplete |
| unsafe_o | output | 1 | Set drive unsafe |
| pad_idx_i | input | 8 | Byte position in the sector |
| pad_cnt_i | input | 9 | Bytes supplied for the sector |
| pad_data_i | input | 8 | Supplied byte at that position |
| pad_last_i | input | 8 | Last supplied byte |
| pad_write_i | input | 1 | Fill for a write (else read) |
| pad_byte_o | output | 8 | Byte to store or deliver |

## Verification
The clocked assertions assume that `req_i` is a single-cycle pulse, and that every input it samples is steady across the clock edge where it is high. The bench drives all inputs on the falling edge and raises `req_i` for exactly one cycle per vector, so those assumptions hold. The assertions also rely on the drive geometry being nonzero and constant within a run. The bench keeps 5 surfaces and 823 cylinders throughout and reaches the range boundaries by moving the cylinder and head, never the geometry.

// File: rtl/sxa_pkg.sv
package sxa_pkg;
  typedef enum logic [2:0] {
    SXA_OK     = 3'd0,
    SXA_XFER   = 3'd1,
    SXA_WPROT  = 3'd2,
    SXA_ADRCMP = 3'd3,
    SXA_CYLOVF = 3'd4
  } sxa_err_e;

  localparam logic [5:0] FN_READ  = 6'h01;
  localparam logic [5:0] FN_WRITE = 6'h02;
  localparam logic [5:0] FN_RCHK  = 6'h03;
  localparam logic [5:0] FN_FMT_LO = 6'h04;
  localparam logic [5:0] FN_FMT_HI = 6'h07;
endpackage

// File: rtl/sxa_check.sv
module sxa_check
  import sxa_pkg::*;
#(
  parameter int CYL_W  = 12,
  parameter int HEAD_W = 5,
  parameter int FN_W   = 6
) (
  input  logic [FN_W-1:0]   func_i,
  input  logic              attached_i,
  input  logic              wprot_i,
  input  logic              first_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [HEAD_W-1:0] surfaces_i,
  input  logic [CYL_W-1:0]  cylinders_i,
  output sxa_err_e          err_o,
  output logic              seek_inc_o,
  output logic              unsafe_o
);
  logic known_fn, fmt_fn;
  sxa_err_e addr_err;
  logic addr_si, addr_us;

  assign known_fn = (func_i >= FN_W'(FN_READ)) && (func_i <= FN_W'(FN_FMT_HI));
  assign fmt_fn   = (func_i >= FN_W'(FN_FMT_LO)) && (func_i <= FN_W'(FN_FMT_HI));

  // priority: attach, write protect, cylinder, head
  always_comb begin
    addr_err = SXA_OK;
    addr_si  = 1'b0;
    addr_us  = 1'b0;
    if (!attached_i) begin
      addr_err = SXA_XFER;
    end else if (wprot_i && func_i == FN_W'(FN_WRITE)) begin
      addr_err = SXA_WPROT;
    end else if (cyl_i >= cylinders_i) begin
      addr_err = SXA_XFER;
      addr_si  = 1'b1;
    end else if (head_i >= surfaces_i) begin
      if (first_i) begin
        addr_err = SXA_ADRCMP;
        addr_us  = 1'b1;
      end else begin
        addr_err = SXA_CYLOVF;
      end
    end
  end

  always_comb begin
    if (!known_fn) begin
      err_o      = SXA_XFER;
      seek_inc_o = 1'b0;
      unsafe_o   = 1'b0;
    end else begin
      err_o      = (fmt_fn && addr_err == SXA_OK) ? SXA_WPROT : addr_err;
      seek_inc_o = addr_si;
      unsafe_o   = addr_us;
    end
  end
endmodule

// File: rtl/sxa_addr.sv
module sxa_addr #(
  parameter int CYL_W  = 12,
  parameter int HEAD_W = 5,
  parameter int SEC_W  = 6,
  localparam int LBA_W = CYL_W + HEAD_W + SEC_W
) (
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [HEAD_W-1:0] surfaces_i,
  output logic [LBA_W-1:0]  lba_o,
  output logic [SEC_W-1:0]  next_sec_o,
  output logic [HEAD_W-1:0] next_head_o,
  output logic              wrap_o
);
  function automatic logic [LBA_W-1:0] lba_of(
    input logic [CYL_W-1:0] c, input logic [HEAD_W-1:0] h,
    input logic [SEC_W-1:0] s, input logic [HEAD_W-1:0] nsurf);
    logic [LBA_W-1:0] track;
    track = LBA_W'(c) * LBA_W'(nsurf) + LBA_W'(h);
    return (track << SEC_W) + LBA_W'(s);
  endfunction

  assign lba_o       = lba_of(cyl_i, head_i, sec_i, surfaces_i);
  assign wrap_o      = &sec_i;
  assign next_sec_o  = sec_i + SEC_W'(1);
  assign next_head_o = head_i + HEAD_W'(wrap_o);
endmodule

// File: rtl/sxa_pad.sv
module sxa_pad #(
  parameter int BYTES = 256,
  localparam int IDX_W = $clog2(BYTES),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [7:0]       data_i,
  input  logic [7:0]       last_i,
  input  logic             write_i,
  output logic [7:0]       byte_o
);
  logic beyond;
  assign beyond = CNT_W'(idx_i) >= cnt_i;
  assign byte_o = !beyond ? data_i : (write_i ? last_i : 8'h00);

  always_comb begin
    if (beyond && !write_i)
      assert_read_fill_zero_R12: assert (byte_o == 8'h00);
  end
endmodule

// File: rtl/sxa_seq.sv
module sxa_seq
  import sxa_pkg::*;
#(
  parameter int CYL_W  = 12,
  parameter int HEAD_W = 5,
  parameter int SEC_W  = 6,
  parameter int FN_W   = 6,
  parameter int BYTES  = 256,
  localparam int LBA_W = CYL_W + HEAD_W + SEC_W,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [FN_W-1:0]   func_i,
  input  logic              attached_i,
  input  logic              wprot_i,
  input  logic              first_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic [HEAD_W-1:0] head_i,
  input  logic [7:0]        sec_i,
  input  logic [HEAD_W-1:0] surfaces_i,
  input  logic [CYL_W-1:0]  cylinders_i,
  output logic              done_o,
  output logic [2:0]        err_o,
  output logic [LBA_W-1:0]  lba_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic [HEAD_W-1:0] head_o,
  output logic              seek_inc_o,
  output logic              unsafe_o,
  input  logic [IDX_W-1:0]  pad_idx_i,
  input  logic [IDX_W:0]    pad_cnt_i,
  input  logic [7:0]        pad_data_i,
  input  logic [7:0]        pad_last_i,
  input  logic              pad_write_i,
  output logic [7:0]        pad_byte_o
);
  sxa_err_e chk_err;
  logic chk_si, chk_us, chk_pass, wrap;
  logic [SEC_W-1:0]  cur_sec, nxt_sec;
  logic [HEAD_W-1:0] nxt_head;
  logic [LBA_W-1:0]  lba_c;

  assign cur_sec  = sec_i[SEC_W-1:0];
  assign chk_pass = (chk_err == SXA_OK);

  sxa_check #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .FN_W(FN_W)) u_check (
    .func_i(func_i), .attached_i(attached_i), .wprot_i(wprot_i),
    .first_i(first_i), .cyl_i(cyl_i), .head_i(head_i),
    .surfaces_i(surfaces_i), .cylinders_i(cylinders_i),
    .err_o(chk_err), .seek_inc_o(chk_si), .unsafe_o(chk_us));

  sxa_addr #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W)) u_addr (
    .cyl_i(cyl_i), .head_i(head_i), .sec_i(cur_sec),
    .surfaces_i(surfaces_i), .lba_o(lba_c), .next_sec_o(nxt_sec),
    .next_head_o(nxt_head), .wrap_o(wrap));

  sxa_pad #(.BYTES(BYTES)) u_pad (
    .idx_i(pad_idx_i), .cnt_i(pad_cnt_i), .data_i(pad_data_i),
    .last_i(pad_last_i), .write_i(pad_write_i), .byte_o(pad_byte_o));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o     <= 1'b0;
      err_o      <= 3'd0;
      lba_o      <= '0;
      sec_o      <= '0;
      head_o     <= '0;
      seek_inc_o <= 1'b0;
      unsafe_o   <= 1'b0;
    end else begin
      done_o <= req_i;
      if (req_i) begin
        err_o      <= chk_err;
        lba_o      <= lba_c;
        sec_o      <= chk_pass ? nxt_sec : cur_sec;
        head_o     <= chk_pass ? nxt_head : head_i;
        seek_inc_o <= chk_si;
        unsafe_o   <= chk_us;
      end
    end
  end

  assert_done_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> done_o);
  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !done_o);
  assert_head_steps_on_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == 3'd0 && sec_o == '0) |-> head_o == $past(head_i) + HEAD_W'(1));
  assert_hold_on_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o != 3'd0) |-> (sec_o == $past(cur_sec) && head_o == $past(head_i)));
  assert_seekinc_is_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && seek_inc_o) |-> err_o == 3'd1);
  assert_unsafe_on_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && unsafe_o) |-> (err_o == 3'd3 && $past(first_i)));
  assert_outputs_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> ($stable(sec_o) && $stable(head_o) && $stable(err_o) && $stable(lba_o)));
endmodule

// File: tb/tb_sxa_seq.sv
module tb_sxa_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NSURF = 5;
  localparam int NCYL  = 823;

  typedef struct packed {
    logic [5:0]  fn;
    logic        att;
    logic        wp;
    logic        first;
    logic [11:0] cyl;
    logic [4:0]  head;
    logic [7:0]  sec;
    logic [2:0]  eerr;
    logic [5:0]  esec;
    logic [4:0]  ehead;
    logic        esi;
    logic        eus;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{6'h01,1'b1,1'b0,1'b1,12'd10,  5'd2, 8'd5,   3'd0,6'd6, 5'd2,1'b0,1'b0}, // R2 R8
    '{6'h01,1'b1,1'b0,1'b0,12'd10,  5'd3, 8'd63,  3'd0,6'd0, 5'd4,1'b0,1'b0}, // R8 wrap
    '{6'h03,1'b1,1'b0,1'b0,12'd100, 5'd4, 8'hC3,  3'd0,6'd4, 5'd4,1'b0,1'b0}, // R8 high bits
    '{6'h02,1'b0,1'b1,1'b1,12'd900, 5'd7, 8'd9,   3'd1,6'd9, 5'd7,1'b0,1'b0}, // R3
    '{6'h02,1'b1,1'b1,1'b1,12'd5,   5'd1, 8'd2,   3'd2,6'd2, 5'd1,1'b0,1'b0}, // R4
    '{6'h01,1'b1,1'b1,1'b1,12'd5,   5'd1, 8'd2,   3'd0,6'd3, 5'd1,1'b0,1'b0}, // R4 read
    '{6'h01,1'b1,1'b0,1'b1,12'd823, 5'd0, 8'd0,   3'd1,6'd0, 5'd0,1'b1,1'b0}, // R5
    '{6'h01,1'b1,1'b0,1'b1,12'd822, 5'd4, 8'd63,  3'd0,6'd0, 5'd5,1'b0,1'b0}, // R5 R2 edge
    '{6'h01,1'b1,1'b0,1'b1,12'd0,   5'd5, 8'd1,   3'd3,6'd1, 5'd5,1'b0,1'b1}, // R6
    '{6'h02,1'b1,1'b0,1'b0,12'd0,   5'd5, 8'd1,   3'd4,6'd1, 5'd5,1'b0,1'b0}, // R7
    '{6'h04,1'b1,1'b0,1'b1,12'd3,   5'd0, 8'd7,   3'd2,6'd7, 5'd0,1'b0,1'b0}, // R10
    '{6'h06,1'b1,1'b0,1'b1,12'd3,   5'd9, 8'd7,   3'd3,6'd7, 5'd9,1'b0,1'b1}, // R10
    '{6'h21,1'b1,1'b0,1'b1,12'd3,   5'd0, 8'd7,   3'd1,6'd7, 5'd0,1'b0,1'b0}, // R11
    '{6'h00,1'b1,1'b0,1'b1,12'd3,   5'd0, 8'd7,   3'd1,6'd7, 5'd0,1'b0,1'b0}, // R11
    '{6'h01,1'b1,1'b0,1'b1,12'd1000,5'd20,8'd0,   3'd1,6'd0, 5'd20,1'b1,1'b0}, // R5 over head
    '{6'h02,1'b1,1'b1,1'b1,12'd1000,5'd0, 8'd0,   3'd2,6'd0, 5'd0,1'b0,1'b0}, // R4 over cyl
    '{6'h07,1'b1,1'b0,1'b0,12'd823, 5'd0, 8'd0,   3'd1,6'd0, 5'd0,1'b1,1'b0}  // R10 R9
  };

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [5:0] fn = '0;
  logic att = 1'b0, wp = 1'b0, first = 1'b0;
  logic [11:0] cyl = '0;
  logic [4:0] head = '0;
  logic [7:0] sec = '0;
  logic [4:0] surf = 5'(NSURF);
  logic [11:0] ncyl = 12'(NCYL);
  logic done, seek_inc, unsafe;
  logic [2:0] err;
  logic [22:0] lba;
  logic [5:0] sec_o;
  logic [4:0] head_o;
  logic [7:0] pidx = '0, pdata = '0, plast = '0, pbyte;
  logic [8:0] pcnt = '0;
  logic pwr = 1'b0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sxa_seq dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .func_i(fn), .attached_i(att),
    .wprot_i(wp), .first_i(first), .cyl_i(cyl), .head_i(head), .sec_i(sec),
    .surfaces_i(surf), .cylinders_i(ncyl), .done_o(done), .err_o(err),
    .lba_o(lba), .sec_o(sec_o), .head_o(head_o), .seek_inc_o(seek_inc),
    .unsafe_o(unsafe), .pad_idx_i(pidx), .pad_cnt_i(pcnt), .pad_data_i(pdata),
    .pad_last_i(plast), .pad_write_i(pwr), .pad_byte_o(pbyte));

  task automatic check(input string req_tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  function automatic longint exp_lba(input int c, input int h, input int s);
    return longint'((c * NSURF + h) * 64 + (s % 64));
  endfunction

  task automatic issue(input vec_t v);
    @(negedge clk);
    fn = v.fn; att = v.att; wp = v.wp; first = v.first;
    cyl = v.cyl; head = v.head; sec = v.sec; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 reset done", done, 0);
    check("R13 reset err", err, 0);
    check("R13 reset sec", sec_o, 0);
    check("R13 reset lba", lba, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i]);
      check("R1 done strobe", done, 1);
      check("R3-R11 error code", err, VECS[i].eerr);
      check("R8/R9 sector", sec_o, VECS[i].esec);
      check("R8/R9 head", head_o, VECS[i].ehead);
      check("R5 seek incomplete", seek_inc, VECS[i].esi);
      check("R6 unsafe", unsafe, VECS[i].eus);
      if (VECS[i].eerr == 3'd0)
        check("R2 linear address", lba,
              exp_lba(int'(VECS[i].cyl), int'(VECS[i].head), int'(VECS[i].sec)));
      @(negedge clk);
      check("R1 done one cycle", done, 0);
    end

    // R13: inputs move without a request, outputs hold
    issue(VECS[0]);
    cyl = 12'd40; head = 5'd1; sec = 8'd30; fn = 6'h21;
    repeat (3) @(negedge clk);
    check("R13 hold sec", sec_o, 6);
    check("R13 hold head", head_o, 2);
    check("R13 hold err", err, 0);
    check("R13 hold lba", lba, exp_lba(10, 2, 5));

    // R12 fill of short sectors
    pidx = 8'd10; pcnt = 9'd20; pdata = 8'hAB; plast = 8'h5C; pwr = 1'b1;
    #1 check("R12 in range", pbyte, 8'hAB);
    pidx = 8'd20;
    #1 check("R12 write fill", pbyte, 8'h5C);
    pwr = 1'b0;
    #1 check("R12 read fill", pbyte, 0);
    pidx = 8'd255; pcnt = 9'd0; pwr = 1'b1;
    #1 check("R12 empty write", pbyte, 8'h5C);
    pcnt = 9'd256; pwr = 1'b0;
    #1 check("R12 full sector", pbyte, 8'hAB);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule